// File: doc/BRIEF.md
# Two-level carry lookahead adder

This block adds two 16-bit unsigned operands and a carry input, with no storage of any kind. The operands are split into four 4-bit slices. Each slice forms a generate term (both bits set) and a propagate term (either bit set) for every bit position. It expands the carry recursion into flat sum-of-products terms, so no carry travels bit by bit inside the slice. It also reports a group generate and a group propagate for its four bits.

A second lookahead unit takes the four group pairs and the carry input. It returns the carry into each upper slice, the final carry output, and a block-level generate and propagate. The block-level pair lets a wider adder treat the whole 16-bit block as one position of a further lookahead level.

The same lookahead unit, parameterised by width, serves both levels. The block therefore needs no control states: it has one combinational path from operands to results. The path is three lookahead levels deep rather than sixteen ripple stages.

Top module: `cla16_adder`

## Requirements
- R1: `sum_out` equals the low 16 bits of `op_a + op_b + carry_in`, treating both operands as unsigned.
- R2: `carry_out` equals bit 16 of the 17-bit unsigned result `op_a + op_b + carry_in`.
- R3: `blk_gen` is 1 exactly when `op_a + op_b` alone, with no carry input, is 65536 or more.
- R4: `blk_prop` is 1 exactly when, in every one of the 16 bit positions, at least one of `op_a` and `op_b` has a 1.
- R5: `carry_out` equals `blk_gen OR (blk_prop AND carry_in)` for every input combination.
- R6: A carry input of 1 travels through all four slices when every position has exactly one operand bit set. For example, `op_a` = 0xFFFF, `op_b` = 0x0000 and `carry_in` = 1 give a sum of 0x0000 and a carry out of 1.
- R7: A carry formed in the top bit of one slice reaches the next slice through the second-level unit. For example, 0x000F + 0x0001 gives 0x0010, 0x00FF + 0x0001 gives 0x0100, and 0x0FFF + 0x0001 gives 0x1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand, unsigned |
| op_b | input | 16 | Second operand, unsigned |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Low 16 bits of the sum |
| carry_out | output | 1 | Carry out of bit 15 |
| blk_prop | output | 1 | Block propagate: every position has at least one operand bit set |
| blk_gen | output | 1 | Block generate: the operands carry out without help from carry_in |

## Verification
The hardest case to reach is a carry input that must cross all three slice boundaries through the second-level unit. That happens only when every bit position has exactly one operand bit set and the carry input is 1. Random operand pairs almost never produce this case, so the vector table holds complementary pairs such as 0xFFFF with 0x0000 and 0xA5A5 with 0x5A5A. The table also holds single-slice propagate runs that end at each slice boundary. Random pairs are then applied with both carry-input values, to cover the general sum and the block generate and propagate results.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int unsigned DEF_WIDTH   = 16;
    localparam int unsigned DEF_SLICE_W = 4;

    // Number of slices needed to cover a word of the given width
    function automatic int unsigned slice_count(int unsigned width, int unsigned slice_w);
        return (width + slice_w - 1) / slice_w;
    endfunction
endpackage

// File: rtl/cla_lookahead.sv
// Flattened lookahead: every carry is a two-level AND-OR of the generate
// and propagate inputs and the carry input; no term depends on another carry.
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] prop_i,
    input  logic [N-1:0] gen_i,
    input  logic         cin_i,
    output logic [N-1:0] carry_o,   // carry_o[i] is the carry into position i+1
    output logic         grp_prop_o,
    output logic         grp_gen_o
);
    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic acc;
            logic run;
            run = cin_i;
            for (int j = 0; j <= i; j++) begin
                run = run & prop_i[j];
            end
            acc = run;
            for (int j = 0; j <= i; j++) begin
                logic term;
                term = gen_i[j];
                for (int k = j + 1; k <= i; k++) begin
                    term = term & prop_i[k];
                end
                acc = acc | term;
            end
            carry_o[i] = acc;
        end
    end

    always_comb begin
        logic gacc;
        gacc = 1'b0;
        for (int j = 0; j < N; j++) begin
            logic term;
            term = gen_i[j];
            for (int k = j + 1; k < N; k++) begin
                term = term & prop_i[k];
            end
            gacc = gacc | term;
        end
        grp_gen_o  = gacc;
        grp_prop_o = &prop_i;
    end

    // R5: top carry consistent with the group pair and the carry input
    always_comb begin
        if (!$isunknown({prop_i, gen_i, cin_i})) begin
            p_group_carry_r5: assert (carry_o[N-1] == (grp_gen_o | (grp_prop_o & cin_i)))
                else $error("p_group_carry_r5: top carry disagrees with group P/G");
        end
    end
endmodule

// File: rtl/cla_slice.sv
module cla_slice #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         grp_prop_o,
    output logic         grp_gen_o
);
    logic [W-1:0] bit_prop;
    logic [W-1:0] bit_gen;
    logic [W-1:0] carry_up;     // carry_up[i] enters position i+1
    logic [W-1:0] carry_at;     // carry entering position i

    assign bit_gen  = a_i & b_i;
    assign bit_prop = a_i | b_i;

    cla_lookahead #(.N(W)) u_look (
        .prop_i     (bit_prop),
        .gen_i      (bit_gen),
        .cin_i      (cin_i),
        .carry_o    (carry_up),
        .grp_prop_o (grp_prop_o),
        .grp_gen_o  (grp_gen_o)
    );

    generate
        if (W > 1) begin : g_multi
            assign carry_at = {carry_up[W-2:0], cin_i};
        end else begin : g_single
            assign carry_at = cin_i;
        end
    endgenerate

    assign sum_o  = a_i ^ b_i ^ carry_at;
    assign cout_o = carry_up[W-1];

    // R1: slice-local arithmetic agrees with a plain add
    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i})) begin
            p_slice_sum_r1: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
                else $error("p_slice_sum_r1: slice result wrong");
        end
    end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH   = DEF_WIDTH,
    parameter int unsigned SLICE_W = DEF_SLICE_W
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             blk_prop,
    output logic             blk_gen
);
    localparam int unsigned NUM_SLICES = slice_count(WIDTH, SLICE_W);
    localparam int unsigned PAD_W      = NUM_SLICES * SLICE_W;

    logic [PAD_W-1:0]      a_pad;
    logic [PAD_W-1:0]      b_pad;
    logic [PAD_W-1:0]      sum_pad;
    logic [NUM_SLICES-1:0] slc_cin;
    logic [NUM_SLICES-1:0] slc_cout;
    logic [NUM_SLICES-1:0] slc_prop;
    logic [NUM_SLICES-1:0] slc_gen;
    logic [NUM_SLICES-1:0] lvl2_carry;

    generate
        if (PAD_W > WIDTH) begin : g_pad
            assign a_pad = {{(PAD_W-WIDTH){1'b0}}, op_a};
            assign b_pad = {{(PAD_W-WIDTH){1'b0}}, op_b};
        end else begin : g_nopad
            assign a_pad = op_a;
            assign b_pad = op_b;
        end

        for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
            if (s == 0) begin : g_first
                assign slc_cin[s] = carry_in;
            end else begin : g_rest
                assign slc_cin[s] = lvl2_carry[s-1];
            end

            cla_slice #(.W(SLICE_W)) u_slice (
                .a_i        (a_pad[s*SLICE_W +: SLICE_W]),
                .b_i        (b_pad[s*SLICE_W +: SLICE_W]),
                .cin_i      (slc_cin[s]),
                .sum_o      (sum_pad[s*SLICE_W +: SLICE_W]),
                .cout_o     (slc_cout[s]),
                .grp_prop_o (slc_prop[s]),
                .grp_gen_o  (slc_gen[s])
            );
        end
    endgenerate

    cla_lookahead #(.N(NUM_SLICES)) u_level2 (
        .prop_i     (slc_prop),
        .gen_i      (slc_gen),
        .cin_i      (carry_in),
        .carry_o    (lvl2_carry),
        .grp_prop_o (blk_prop),
        .grp_gen_o  (blk_gen)
    );

    assign sum_out   = sum_pad[WIDTH-1:0];
    assign carry_out = lvl2_carry[NUM_SLICES-1];

    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in})) begin
            p_sum_r1: assert ({carry_out, sum_out} ==
                              ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
                else $error("p_sum_r1: sum or carry wrong");
            p_gen_r3: assert (blk_gen == (({1'b0, op_a} + {1'b0, op_b}) >> WIDTH))
                else $error("p_gen_r3: block generate wrong");
            p_prop_r4: assert (blk_prop == (&(op_a | op_b)))
                else $error("p_prop_r4: block propagate wrong");
            p_boundary_r7: assert (slc_cout == lvl2_carry)
                else $error("p_boundary_r7: slice carry and lookahead carry differ");
        end
    end
endmodule

// File: tb/cla16_adder_tb.sv
`timescale 1ns/1ps
module cla16_adder_tb;
    localparam int W = 16;
    localparam int NV = 18;
    localparam int NRAND = 3000;
    localparam int WATCHDOG_NS = 1000000;

    // {op_a, op_b, carry_in}
    localparam logic [32:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 1'b0},
        {16'h0000, 16'h0000, 1'b1},
        {16'hFFFF, 16'h0000, 1'b1},   // R6
        {16'h0000, 16'hFFFF, 1'b1},   // R6
        {16'hA5A5, 16'h5A5A, 1'b1},   // R6
        {16'hA5A5, 16'h5A5A, 1'b0},
        {16'hFFFF, 16'hFFFF, 1'b1},
        {16'hFFFF, 16'hFFFF, 1'b0},
        {16'h000F, 16'h0001, 1'b0},   // R7
        {16'h00FF, 16'h0001, 1'b0},   // R7
        {16'h0FFF, 16'h0001, 1'b0},   // R7
        {16'h000F, 16'h0000, 1'b1},   // R7
        {16'h00F0, 16'h0010, 1'b0},   // R7
        {16'h8000, 16'h8000, 1'b0},
        {16'h7FFF, 16'h0001, 1'b0},
        {16'h1234, 16'hEDCB, 1'b1},
        {16'hF0F0, 16'h0F0F, 1'b0},
        {16'hBEEF, 16'h4110, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic carry_in = 1'b0;
    logic [W-1:0] sum_out;
    logic carry_out, blk_prop, blk_gen;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    cla16_adder u_dut (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .sum_out(sum_out), .carry_out(carry_out),
        .blk_prop(blk_prop), .blk_gen(blk_gen)
    );

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (a=%h b=%h cin=%b)",
                     req, act, exp, op_a, op_b, carry_in);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci,
                         input string tag);
        logic [W:0] full;
        logic [W:0] nocin;
        @(posedge clk);
        #1;
        op_a = a; op_b = b; carry_in = ci;
        @(negedge clk);
        full  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        nocin = {1'b0, a} + {1'b0, b};
        check({"R1 ", tag}, {1'b0, sum_out}, {1'b0, full[W-1:0]});
        check({"R2 ", tag}, {{W{1'b0}}, carry_out}, {{W{1'b0}}, full[W]});
        check({"R3 ", tag}, {{W{1'b0}}, blk_gen}, {{W{1'b0}}, nocin[W]});
        check({"R4 ", tag}, {{W{1'b0}}, blk_prop}, {{W{1'b0}}, &(a | b)});
        check({"R5 ", tag}, {{W{1'b0}}, carry_out}, {{W{1'b0}}, blk_gen | (blk_prop & ci)});
    endtask

    initial begin
        #(WATCHDOG_NS);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset state: zero operands give all-zero outputs (R1, R2)
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset sum", {1'b0, sum_out}, '0);
        check("R2 reset carry", {{W{1'b0}}, carry_out}, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][32:17], VEC[i][16:1], VEC[i][0], "table");
        end

        // R6: carry input crossing all slices
        apply(16'hFFFF, 16'h0000, 1'b1, "R6 full propagate");
        check("R6 sum zero", {1'b0, sum_out}, '0);
        check("R6 carry out", {{W{1'b0}}, carry_out}, 17'd1);

        // R7: carry out of each slice's top bit into the next slice
        for (int s = 1; s < 4; s++) begin
            logic [W-1:0] low_ones;
            low_ones = (16'h1 << (4 * s)) - 16'h1;
            apply(low_ones, 16'h0001, 1'b0, "R7 boundary");
            check("R7 boundary sum", {1'b0, sum_out}, {1'b0, 16'h1 << (4 * s)});
        end

        // Random pairs with both carry-input values
        for (int i = 0; i < NRAND; i++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            ra = W'($urandom);
            rb = W'($urandom);
            apply(ra, rb, 1'b0, "random");
            apply(ra, rb, 1'b1, "random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule